// File: doc/BRIEF.md
# Load-Protect Alias Detection Table

This block lets a scheduler hoist loads above older stores and still catch the cases where that reordering was wrong. When a hoisted load issues, it is registered in one slot of a small table. The slot holds the load's start address and its access width. Each later store arrives with a slot-select mask. The store's byte range is compared only against the registered loads that the mask picks out.

If any picked, live slot overlaps the store, the block raises an alias trap one cycle later. The trap carries the lowest-numbered conflicting slot and a vector of every conflicting slot, so that recovery logic can replay the affected loads. A flush input empties the table when a group of speculative work commits or rolls back. Recovery itself happens outside the block.

Top module: `alias_guard_table`

## Requirements
- R1: While `rst_n` is low at a clock edge, every slot becomes empty and `trap_o`, `trap_idx_o` and `trap_hits_o` become zero.
- R2: A cycle with `ld_valid` high writes `ld_addr` and `ld_size` into slot `ld_idx` and marks that slot live. Writing an already live slot replaces its previous contents.
- R3: Width codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. A store conflicts with a slot when the ranges [st_addr, st_addr+width) and [slot addr, slot addr+width) share at least one byte. The ranges do not wrap at the top of the address space. Ranges that only touch at an edge do not conflict.
- R4: Bit i of `st_mask` selects slot i. A slot whose mask bit is 0 never causes a trap, even when it overlaps.
- R5: An empty slot never causes a trap, whatever its mask bit.
- R6: `trap_o` is high in the cycle after a store check (`st_valid` high) that finds at least one conflict. It is low in every other cycle, including every cycle after a clock edge with no store.
- R7: `trap_hits_o` has bit i set exactly for each conflicting slot i of the previous store check. `trap_idx_o` gives the lowest set bit of `trap_hits_o`, and is 0 when there is no trap.
- R8: A cycle with `clr` high empties every slot. A load registered in the same cycle as `clr` stays live.
- R9: A store and a load in the same cycle: the store is checked against the table as it was before that load's write.
- R10: A store in the same cycle as `clr` is checked against the table contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Empty every slot |
| ld_valid | input | 1 | Register a protected load this cycle |
| ld_idx | input | 3 | Slot to write |
| ld_addr | input | 32 | Load start byte address |
| ld_size | input | 2 | Load width code |
| st_valid | input | 1 | Check a store this cycle |
| st_addr | input | 32 | Store start byte address |
| st_size | input | 2 | Store width code |
| st_mask | input | 8 | Slots the store is checked against |
| trap_o | output | 1 | Alias trap, one cycle after the store |
| trap_idx_o | output | 3 | Lowest conflicting slot |
| trap_hits_o | output | 8 | All conflicting slots |

## Verification
The bench places stores exactly one byte before and exactly at the end of protected ranges, for every width code. An off-by-one comparison would trap on touching ranges or miss a one-byte overlap. It repeats the two-load mask example: a store against both loads traps on either, and a later store masked to the second load traps only on it. A design that ignored the mask would report the first slot there. Same-cycle load/store and flush/store cases show whether the store sees the table before or after the update; a design with the wrong order would trap on a load written in that same cycle, or lose the trap on a flushed slot. Multi-slot hits check that the lowest slot is reported rather than the highest.

// File: rtl/alias_pkg.sv
// Shared types and helpers for the alias detection table.
// Assumes width codes 0..3 meaning 1, 2, 4 and 8 bytes.
package alias_pkg;

    typedef logic [1:0] size_code_t;

    // Convert a width code into a byte count.
    function automatic logic [3:0] size_bytes(input size_code_t code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/alias_slot.sv
// One table slot: holds a protected load range and compares it with the
// current store range. Assumes the store range arrives already widened by
// one bit so that ranges never wrap.
module alias_slot
    import alias_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  size_code_t        wr_size,
    input  logic [ADDR_W:0]   st_lo,
    input  logic [ADDR_W:0]   st_hi,
    output logic              valid_o,
    output logic              hit_o
);
    localparam int PAD_W = ADDR_W + 1 - 4;

    logic              valid_q;
    logic [ADDR_W-1:0] base_q;
    size_code_t        size_q;
    logic [ADDR_W:0]   ld_lo;
    logic [ADDR_W:0]   ld_hi;

    // Slot storage: a write wins over a flush for this slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            base_q  <= '0;
            size_q  <= '0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            base_q  <= wr_addr;
            size_q  <= wr_size;
        end else if (clr) begin
            valid_q <= 1'b0;
        end
    end

    // Half-open range overlap between the stored load and the store.
    always_comb begin
        ld_lo = {1'b0, base_q};
        ld_hi = ld_lo + {{PAD_W{1'b0}}, size_bytes(size_q)};
        hit_o = valid_q && (st_lo < ld_hi) && (ld_lo < st_hi);
    end

    assign valid_o = valid_q;

endmodule

// File: rtl/alias_first_set.sv
// Lowest-set-bit encoder over a hit vector. Assumes WIDTH >= 2.
module alias_first_set #(
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is assigned last.
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/alias_guard_table.sv
// Protected-load table with masked store checks. Each slot records a load
// range; a store is compared only against the live slots that its mask
// selects, and a registered trap reports the conflicts one cycle later.
// Assumes at most one load and one store per cycle; a store sees the table
// as it was before any write or flush in its own cycle.
module alias_guard_table
    import alias_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   ld_valid,
    input  logic [IDX_W-1:0]       ld_idx,
    input  logic [ADDR_W-1:0]      ld_addr,
    input  logic [1:0]             ld_size,
    input  logic                   st_valid,
    input  logic [ADDR_W-1:0]      st_addr,
    input  logic [1:0]             st_size,
    input  logic [NUM_ENTRIES-1:0] st_mask,
    output logic                   trap_o,
    output logic [IDX_W-1:0]       trap_idx_o,
    output logic [NUM_ENTRIES-1:0] trap_hits_o
);
    localparam int PAD_W = ADDR_W + 1 - 4;

    logic [ADDR_W:0]        st_lo;
    logic [ADDR_W:0]        st_hi;
    logic [NUM_ENTRIES-1:0] slot_valid;
    logic [NUM_ENTRIES-1:0] slot_hit;
    logic [NUM_ENTRIES-1:0] sel_hit;
    logic [IDX_W-1:0]       first_idx;

    // Store byte range, widened one bit to keep the end from wrapping.
    always_comb begin
        st_lo = {1'b0, st_addr};
        st_hi = st_lo + {{PAD_W{1'b0}}, size_bytes(st_size)};
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        alias_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .wr_en   (ld_valid && (ld_idx == IDX_W'(g))),
            .wr_addr (ld_addr),
            .wr_size (ld_size),
            .st_lo   (st_lo),
            .st_hi   (st_hi),
            .valid_o (slot_valid[g]),
            .hit_o   (slot_hit[g])
        );
    end

    // Keep only the slots the store actually asked about.
    assign sel_hit = st_valid ? (slot_hit & st_mask) : '0;

    alias_first_set #(.WIDTH(NUM_ENTRIES), .IDX_W(IDX_W)) u_first (
        .vec (sel_hit),
        .idx (first_idx)
    );

    // Register the trap report for the cycle after the check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_o      <= 1'b0;
            trap_idx_o  <= '0;
            trap_hits_o <= '0;
        end else begin
            trap_o      <= |sel_hit;
            trap_idx_o  <= first_idx;
            trap_hits_o <= sel_hit;
        end
    end

endmodule

// File: rtl/alias_guard_chk.sv
// Property checker for alias_guard_table, attached by bind below.
module alias_guard_chk #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clr,
    input logic                   ld_valid,
    input logic [IDX_W-1:0]       ld_idx,
    input logic                   st_valid,
    input logic [NUM_ENTRIES-1:0] st_mask,
    input logic [NUM_ENTRIES-1:0] slot_valid,
    input logic                   trap_o,
    input logic [IDX_W-1:0]       trap_idx_o,
    input logic [NUM_ENTRIES-1:0] trap_hits_o
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (slot_valid == '0) && !trap_o && (trap_hits_o == '0));

    assert_load_marks_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> slot_valid[$past(ld_idx)]);

    assert_mask_limits_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> (trap_hits_o & ~$past(st_mask)) == '0);

    assert_empty_slot_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> (trap_hits_o & ~$past(slot_valid)) == '0);

    assert_no_store_no_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !trap_o && (trap_hits_o == '0));

    assert_idx_is_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> trap_hits_o[trap_idx_o]
                   && ((trap_hits_o & ((NUM_ENTRIES'(1) << trap_idx_o) - 1'b1)) == '0));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld_valid) |=> slot_valid == '0);

endmodule

bind alias_guard_table alias_guard_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .ld_valid    (ld_valid),
    .ld_idx      (ld_idx),
    .st_valid    (st_valid),
    .st_mask     (st_mask),
    .slot_valid  (slot_valid),
    .trap_o      (trap_o),
    .trap_idx_o  (trap_idx_o),
    .trap_hits_o (trap_hits_o)
);

// File: tb/tb_alias_guard_table.sv
// Directed bench: a small reference table is kept here and each scenario
// task drives one or more cycles and compares the trap report.
module tb_alias_guard_table;
    localparam int  N          = 8;
    localparam int  AW         = 32;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clr;
    logic          ld_valid;
    logic [2:0]    ld_idx;
    logic [AW-1:0] ld_addr;
    logic [1:0]    ld_size;
    logic          st_valid;
    logic [AW-1:0] st_addr;
    logic [1:0]    st_size;
    logic [N-1:0]  st_mask;
    logic          trap_o;
    logic [2:0]    trap_idx_o;
    logic [N-1:0]  trap_hits_o;

    int vectors = 0;
    int errors  = 0;

    logic [AW:0]  m_lo [N];
    logic [AW:0]  m_hi [N];
    logic [N-1:0] m_live;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alias_guard_table dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_addr(ld_addr), .ld_size(ld_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size), .st_mask(st_mask),
        .trap_o(trap_o), .trap_idx_o(trap_idx_o), .trap_hits_o(trap_hits_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: optional load, store and flush; checks the report afterwards.
    task automatic step(input bit do_ld, input int idx, input logic [AW-1:0] la, input int ls,
                        input bit do_st, input logic [AW-1:0] sa, input int ss,
                        input logic [N-1:0] mask, input bit do_clr, input string req);
        logic [N-1:0] exp_hits;
        logic [AW:0]  s_lo, s_hi;
        int           exp_idx;
        @(negedge clk);
        ld_valid = do_ld; ld_idx = 3'(idx); ld_addr = la; ld_size = 2'(ls);
        st_valid = do_st; st_addr = sa; st_size = 2'(ss); st_mask = mask; clr = do_clr;
        // Expected result uses the table before this cycle's updates (R9, R10).
        s_lo = {1'b0, sa};
        s_hi = s_lo + (33'd1 << ss);
        exp_hits = '0;
        if (do_st)
            for (int i = 0; i < N; i++)
                if (m_live[i] && mask[i] && s_lo < m_hi[i] && m_lo[i] < s_hi) exp_hits[i] = 1'b1;
        exp_idx = 0;
        for (int i = N - 1; i >= 0; i--) if (exp_hits[i]) exp_idx = i;
        @(posedge clk);
        if (do_clr) m_live = '0;
        if (do_ld) begin
            m_lo[idx] = {1'b0, la};
            m_hi[idx] = {1'b0, la} + (33'd1 << ls);
            m_live[idx] = 1'b1;
        end
        @(negedge clk);
        ld_valid = 0; st_valid = 0; clr = 0;
        check(trap_o == (exp_hits != '0), {req, " trap"}, int'(trap_o), int'(exp_hits != '0));
        check(trap_hits_o == exp_hits, {req, " hits"}, int'(trap_hits_o), int'(exp_hits));
        check(int'(trap_idx_o) == exp_idx, {req, " idx"}, int'(trap_idx_o), exp_idx);
    endtask

    task automatic protect(input int idx, input logic [AW-1:0] a, input int s, input string req);
        step(1, idx, a, s, 0, '0, 0, '0, 0, req);
    endtask

    task automatic store(input logic [AW-1:0] a, input int s, input logic [N-1:0] m, input string req);
        step(0, 0, '0, 0, 1, a, s, m, 0, req);
    endtask

    task automatic t_reset_R1;
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(trap_o == 0 && trap_hits_o == 0 && trap_idx_o == 0, "R1 reset outputs",
              int'(trap_hits_o), 0);
        rst_n = 1;
        m_live = '0;
        store(32'h100, 3, 8'hFF, "R1 empty after reset");
    endtask

    task automatic t_sizes_R3;
        // Each width: last byte inside hits, first byte past the end misses.
        for (int s = 0; s < 4; s++) begin
            protect(s, 32'h1000 + 32'(s) * 32'h40, s, "R2 write");
            store(32'h1000 + 32'(s) * 32'h40 + (32'd1 << s) - 1, 0, 8'hFF, "R3 last byte");
            store(32'h1000 + 32'(s) * 32'h40 + (32'd1 << s), 3, 8'hFF, "R3 touch above");
            store(32'h1000 + 32'(s) * 32'h40 - 8, 3, 8'hFF, "R3 touch below");
            store(32'h1000 + 32'(s) * 32'h40 - 7, 3, 8'hFF, "R3 one byte below");
        end
        protect(7, 32'hFFFF_FFF8, 3, "R3 top of space");
        store(32'hFFFF_FFFC, 2, 8'h80, "R3 no wrap hit");
        store(32'h0000_0000, 3, 8'h80, "R3 no wrap miss");
    endtask

    task automatic t_mask_R4;
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R8 flush with load");
        protect(1, 32'h2000, 2, "R2 first");
        protect(2, 32'h2004, 2, "R2 second");
        store(32'h2000, 3, 8'b0000_0110, "R4 both selected");
        store(32'h2002, 0, 8'b0000_0110, "R4 matches first");
        store(32'h2000, 3, 8'b0000_0100, "R4 only second");
        store(32'h2000, 1, 8'b0000_0100, "R4 first unselected");
        store(32'h2000, 3, 8'b0000_0000, "R4 empty mask");
    endtask

    task automatic t_live_R5_R7;
        store(32'h2000, 3, 8'b1111_1000, "R5 empty slots selected");
        protect(6, 32'h2006, 0, "R2 six");
        protect(4, 32'h2001, 1, "R2 four");
        store(32'h2000, 3, 8'hFF, "R7 lowest of many");
        protect(1, 32'h9000, 3, "R2 overwrite");
        store(32'h2000, 3, 8'hFF, "R7 after overwrite");
        step(0, 0, 0, 0, 0, 32'h2000, 3, 8'hFF, 0, "R6 no store");
    endtask

    task automatic t_order_R8_R10;
        step(1, 3, 32'h3000, 2, 1, 32'h3000, 2, 8'hFF, 0, "R9 same-cycle load");
        store(32'h3000, 2, 8'b0000_1000, "R9 load then visible");
        step(0, 0, 0, 0, 1, 32'h3000, 2, 8'hFF, 1, "R10 store with flush");
        store(32'h3000, 2, 8'hFF, "R8 flushed");
        step(1, 5, 32'h3100, 0, 0, 0, 0, 0, 1, "R8 load with flush");
        store(32'h3100, 0, 8'hFF, "R8 load kept");
    endtask

    initial begin
        clr = 0; ld_valid = 0; ld_idx = 0; ld_addr = 0; ld_size = 0;
        st_valid = 0; st_addr = 0; st_size = 0; st_mask = 0; rst_n = 0;
        m_live = '0;
        for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        t_reset_R1();
        t_sizes_R3();
        t_mask_R4();
        t_live_R5_R7();
        t_order_R8_R10();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule